// File: doc/BRIEF.md
# Integer Condition Flag Generator

This block works out the next values of the five condition flags that follow an integer operation: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It is purely combinational. The ALU datapath hands it the source operand, the destination operand, the result, the flags as they stand now, a four-bit operation class and a two-bit operand size. The block returns the next value of each flag and one write enable per flag, so the status register around it stores only the flags that the operation defines.

Only the sign bits of the operands and the result, taken at the selected size, and the zero test of the result are needed. The carry and overflow equations are therefore evaluated on three bits per operation. Extend is kept apart from carry, so that compare and logical instructions can leave it untouched between the steps of a multiprecision sequence. The extended forms of add, subtract and negate can only clear Z, never set it, so that Z reports on the whole of a chained multi-word result.

Flag vectors on `flags_i`, `flags_o` and `flag_we_o` use bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.

Top module: `ccf_gen`

## Requirements
- R1: N equals the result bit at the sign position for the size: bit 7 for size 0, bit 15 for size 1, bit 31 for size 2 or size 3. It is written by every class code from 0 to 9.
- R2: For class codes 0, 1, 4, 5, 7, 8 and 9, Z is 1 exactly when every result bit at or below the sign position is 0. Result bits above the sign position have no effect on any flag.
- R3: Add (class 0) and add-with-extend (class 2) give V = S·D·~R + ~S·~D·R and C = S·D + D·~R + S·~R, where S, D and R are the sign-position bits of source, destination and result.
- R4: Subtract (class 1) and subtract-with-extend (class 3) give V = ~S·D·~R + S·~D·R and C = S·~D + R·~D + S·R.
- R5: Negate (class 5) and negate-with-extend (class 6) give V = D·R and C = D + R.
- R6: For classes 2, 3 and 6 the new Z is the incoming Z AND the result-is-zero test, so a zero result leaves Z as it was and a nonzero result clears it.
- R7: The logic, move and test class (code 7) forces V and C to 0, sets N and Z from the result and does not write X.
- R8: Divide (class 8) sets V from `div_ovf_i`, multiply (class 9) sets V from `mul_ovf_i`. Both force C to 0, set N and Z from the result and do not write X.
- R9: Compare (class 4) writes N, Z, V and C with the subtract equations of R4 and does not write X.
- R10: X is written by classes 0, 1, 2, 3, 5 and 6 only, and it then takes the same value as the new C.
- R11: Each flag whose write enable is 0 comes out on `flags_o` with its `flags_i` value. Class codes 10 to 15 write no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | DATA_W | Source operand |
| dst_i | input | DATA_W | Destination operand |
| res_i | input | DATA_W | Operation result |
| flags_i | input | 5 | Current flags {X,N,Z,V,C} |
| op_cls_i | input | 4 | Operation class code |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| div_ovf_i | input | 1 | Division overflow indication |
| mul_ovf_i | input | 1 | Multiplication overflow indication |
| flags_o | output | 5 | Next flags {X,N,Z,V,C} |
| flag_we_o | output | 5 | Per-flag write enables {X,N,Z,V,C} |

## Verification
The hardest case to reach is a sticky Z in the extended classes where only the bits below the sign position are zero. A random result almost never lands there, and a random incoming Z is useless unless it is crossed with both outcomes. Directed vectors therefore set bits above the byte and word sign positions while the lower bits are zero, and they pair each such result with an incoming Z of 0 and of 1. Sign-boundary operands such as 0x7F+0x01 and 0x80000000 negated give the overflow corners, and a long random run covers every class code at every size.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

   // flag vector bit positions
   localparam int FLG_X = 4;
   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_V = 1;
   localparam int FLG_C = 0;
   localparam int FLG_W = 5;

   typedef logic [3:0] opc_t;

   localparam opc_t OPC_ADD   = 4'd0;
   localparam opc_t OPC_SUB   = 4'd1;
   localparam opc_t OPC_ADDX  = 4'd2;
   localparam opc_t OPC_SUBX  = 4'd3;
   localparam opc_t OPC_CMP   = 4'd4;
   localparam opc_t OPC_NEG   = 4'd5;
   localparam opc_t OPC_NEGX  = 4'd6;
   localparam opc_t OPC_LOGIC = 4'd7;
   localparam opc_t OPC_DIV   = 4'd8;
   localparam opc_t OPC_MUL   = 4'd9;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_ALT  = 2'd3
   } size_e;

   // decoded control for one operation class
   typedef struct packed {
      logic sel_add;
      logic sel_sub;
      logic sel_neg;
      logic sel_div;
      logic sel_mul;
      logic sticky_z;
      logic wr_x;
      logic wr_nzvc;
   } cls_t;

endpackage

// File: rtl/ccf_size_tap.sv
module ccf_size_tap
   import ccf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic [1:0]        size_i,
   output logic              sm_o,
   output logic              dm_o,
   output logic              rm_o,
   output logic              rzero_o
);

   localparam int N_LANES = 3;

   logic [N_LANES-1:0] lane_sm;
   logic [N_LANES-1:0] lane_dm;
   logic [N_LANES-1:0] lane_rm;
   logic [N_LANES-1:0] lane_zero;

   // lane g covers the low DATA_W >> (2-g) bits: quarter, half, full
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LANE_W = DATA_W >> (N_LANES - 1 - g);
      assign lane_sm[g]   = src_i[LANE_W-1];
      assign lane_dm[g]   = dst_i[LANE_W-1];
      assign lane_rm[g]   = res_i[LANE_W-1];
      assign lane_zero[g] = ~|res_i[LANE_W-1:0];
   end

   logic [1:0] lane_sel;

   always_comb begin
      unique case (size_e'(size_i))
         SZ_BYTE: lane_sel = 2'd0;
         SZ_WORD: lane_sel = 2'd1;
         default: lane_sel = 2'd2;
      endcase
   end

   assign sm_o    = lane_sm[lane_sel];
   assign dm_o    = lane_dm[lane_sel];
   assign rm_o    = lane_rm[lane_sel];
   assign rzero_o = lane_zero[lane_sel];

endmodule

// File: rtl/ccf_decode.sv
module ccf_decode
   import ccf_pkg::*;
(
   input  logic [3:0] op_cls_i,
   output cls_t       cls_o
);

   always_comb begin
      cls_o = '0;
      case (op_cls_i)
         OPC_ADD: begin
            cls_o.sel_add = 1'b1;
            cls_o.wr_x    = 1'b1;
            cls_o.wr_nzvc = 1'b1;
         end
         OPC_SUB: begin
            cls_o.sel_sub = 1'b1;
            cls_o.wr_x    = 1'b1;
            cls_o.wr_nzvc = 1'b1;
         end
         OPC_ADDX: begin
            cls_o.sel_add  = 1'b1;
            cls_o.sticky_z = 1'b1;
            cls_o.wr_x     = 1'b1;
            cls_o.wr_nzvc  = 1'b1;
         end
         OPC_SUBX: begin
            cls_o.sel_sub  = 1'b1;
            cls_o.sticky_z = 1'b1;
            cls_o.wr_x     = 1'b1;
            cls_o.wr_nzvc  = 1'b1;
         end
         OPC_CMP: begin
            cls_o.sel_sub = 1'b1;
            cls_o.wr_nzvc = 1'b1;
         end
         OPC_NEG: begin
            cls_o.sel_neg = 1'b1;
            cls_o.wr_x    = 1'b1;
            cls_o.wr_nzvc = 1'b1;
         end
         OPC_NEGX: begin
            cls_o.sel_neg  = 1'b1;
            cls_o.sticky_z = 1'b1;
            cls_o.wr_x     = 1'b1;
            cls_o.wr_nzvc  = 1'b1;
         end
         OPC_LOGIC: begin
            cls_o.wr_nzvc = 1'b1;
         end
         OPC_DIV: begin
            cls_o.sel_div = 1'b1;
            cls_o.wr_nzvc = 1'b1;
         end
         OPC_MUL: begin
            cls_o.sel_mul = 1'b1;
            cls_o.wr_nzvc = 1'b1;
         end
         default: cls_o = '0;
      endcase
   end

   // at most one V/C source is ever chosen
   always_comb begin
      a_r11_one_vc_source: assert ($onehot0({cls_o.sel_add, cls_o.sel_sub, cls_o.sel_neg,
                                              cls_o.sel_div, cls_o.sel_mul}))
         else $error("more than one V/C source decoded");
   end

endmodule

// File: rtl/ccf_arith.sv
module ccf_arith
   import ccf_pkg::*;
(
   input  logic sm_i,
   input  logic dm_i,
   input  logic rm_i,
   input  cls_t cls_i,
   input  logic div_ovf_i,
   input  logic mul_ovf_i,
   output logic v_o,
   output logic c_o
);

   logic v_add, c_add;
   logic v_sub, c_sub;
   logic v_neg, c_neg;

   assign v_add = (sm_i & dm_i & ~rm_i) | (~sm_i & ~dm_i & rm_i);
   assign c_add = (sm_i & dm_i) | (dm_i & ~rm_i) | (sm_i & ~rm_i);

   assign v_sub = (~sm_i & dm_i & ~rm_i) | (sm_i & ~dm_i & rm_i);
   assign c_sub = (sm_i & ~dm_i) | (rm_i & ~dm_i) | (sm_i & rm_i);

   assign v_neg = dm_i & rm_i;
   assign c_neg = dm_i | rm_i;

   always_comb begin
      v_o = 1'b0;
      c_o = 1'b0;
      if (cls_i.sel_add) begin
         v_o = v_add;
         c_o = c_add;
      end else if (cls_i.sel_sub) begin
         v_o = v_sub;
         c_o = c_sub;
      end else if (cls_i.sel_neg) begin
         v_o = v_neg;
         c_o = c_neg;
      end else if (cls_i.sel_div) begin
         v_o = div_ovf_i;
      end else if (cls_i.sel_mul) begin
         v_o = mul_ovf_i;
      end
   end

   // R5: a zero destination with a zero result never borrows on negate
   always_comb begin
      if (cls_i.sel_neg && !dm_i && !rm_i)
         a_r5_neg_zero_no_carry: assert (!c_o && !v_o)
            else $error("negate of zero reported carry or overflow");
   end

endmodule

// File: rtl/ccf_gen.sv
module ccf_gen
   import ccf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic [4:0]        flags_i,
   input  logic [3:0]        op_cls_i,
   input  logic [1:0]        size_i,
   input  logic              div_ovf_i,
   input  logic              mul_ovf_i,
   output logic [4:0]        flags_o,
   output logic [4:0]        flag_we_o
);

   if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("ccf_gen: DATA_W must be a multiple of 4 and at least 8");
   end

   logic sm, dm, rm, rzero;
   cls_t cls;
   logic v_calc, c_calc;
   logic z_calc;
   logic [FLG_W-1:0] calc;
   logic [FLG_W-1:0] we;

   ccf_size_tap #(.DATA_W(DATA_W)) u_tap (
      .src_i   (src_i),
      .dst_i   (dst_i),
      .res_i   (res_i),
      .size_i  (size_i),
      .sm_o    (sm),
      .dm_o    (dm),
      .rm_o    (rm),
      .rzero_o (rzero)
   );

   ccf_decode u_dec (
      .op_cls_i (op_cls_i),
      .cls_o    (cls)
   );

   ccf_arith u_arith (
      .sm_i      (sm),
      .dm_i      (dm),
      .rm_i      (rm),
      .cls_i     (cls),
      .div_ovf_i (div_ovf_i),
      .mul_ovf_i (mul_ovf_i),
      .v_o       (v_calc),
      .c_o       (c_calc)
   );

   // extended classes can only clear Z
   assign z_calc = cls.sticky_z ? (flags_i[FLG_Z] & rzero) : rzero;

   always_comb begin
      calc        = '0;
      calc[FLG_X] = c_calc;
      calc[FLG_N] = rm;
      calc[FLG_Z] = z_calc;
      calc[FLG_V] = v_calc;
      calc[FLG_C] = c_calc;
   end

   always_comb begin
      we        = '0;
      we[FLG_X] = cls.wr_x;
      we[FLG_N] = cls.wr_nzvc;
      we[FLG_Z] = cls.wr_nzvc;
      we[FLG_V] = cls.wr_nzvc;
      we[FLG_C] = cls.wr_nzvc;
   end

   for (genvar f = 0; f < FLG_W; f++) begin : g_merge
      assign flags_o[f] = we[f] ? calc[f] : flags_i[f];
   end

   assign flag_we_o = we;

   always_comb begin
      // R10: whenever X is written it matches the new carry
      if (flag_we_o[FLG_X])
         a_r10_x_tracks_c: assert (flags_o[FLG_X] == flags_o[FLG_C])
            else $error("X differs from C");
      // R7: logic class clears V and C and keeps X
      if (op_cls_i == OPC_LOGIC)
         a_r7_logic_clears_vc: assert (!flags_o[FLG_V] && !flags_o[FLG_C] && !flag_we_o[FLG_X])
            else $error("logic class V/C/X wrong");
      // R9: compare leaves X alone
      if (op_cls_i == OPC_CMP)
         a_r9_cmp_keeps_x: assert (!flag_we_o[FLG_X] && flags_o[FLG_X] == flags_i[FLG_X])
            else $error("compare touched X");
      // R6: a clear incoming Z stays clear on extended classes
      if ((op_cls_i == OPC_ADDX || op_cls_i == OPC_SUBX || op_cls_i == OPC_NEGX) && !flags_i[FLG_Z])
         a_r6_sticky_z: assert (!flags_o[FLG_Z])
            else $error("extended class set Z");
      // R8: divide and multiply never report carry
      if (op_cls_i == OPC_DIV || op_cls_i == OPC_MUL)
         a_r8_divmul_no_carry: assert (!flags_o[FLG_C])
            else $error("divide/multiply reported carry");
      // R11: reserved codes write nothing and pass flags through
      if (op_cls_i > OPC_MUL)
         a_r11_reserved_quiet: assert (flag_we_o == '0 && flags_o == flags_i)
            else $error("reserved class wrote flags");
   end

endmodule

// File: tb/ccf_gen_test.sv
module ccf_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 32;
   localparam int N_RANDOM   = 4000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] src, dst, res;
   logic [4:0]    fin;
   logic [3:0]    opc;
   logic [1:0]    sz;
   logic          dovf, movf;
   logic [4:0]    fout, fwe;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccf_gen #(.DATA_W(DW)) uut (
      .src_i     (src),
      .dst_i     (dst),
      .res_i     (res),
      .flags_i   (fin),
      .op_cls_i  (opc),
      .size_i    (sz),
      .div_ovf_i (dovf),
      .mul_ovf_i (movf),
      .flags_o   (fout),
      .flag_we_o (fwe)
   );

   // behavioural model: returns {we, flags}
   function automatic logic [9:0] model(input logic [31:0] s, input logic [31:0] d,
                                        input logic [31:0] r, input logic [4:0] f,
                                        input int op, input int size,
                                        input bit dv, input bit mv);
      int  top;
      bit  sb, db, rb, zero, n, z, v, c, x;
      bit  wx, wrest;
      logic [31:0] lowr;
      top  = (size == 0) ? 7 : (size == 1) ? 15 : 31;
      sb   = s[top];
      db   = d[top];
      rb   = r[top];
      lowr = r << (31 - top);
      zero = (lowr == 32'd0);
      n = rb; z = zero; v = 0; c = 0;
      wx = 0; wrest = 1;
      case (op)
         0, 2: begin
            v = (sb == db) && (rb != sb);
            c = (int'(sb) + int'(db) + int'(!rb)) >= 2;
            wx = 1;
         end
         1, 3, 4: begin
            v = (sb != db) && (rb != db);
            c = (int'(sb) + int'(!db) + int'(rb)) >= 2;
            wx = (op != 4);
         end
         5, 6: begin
            v = db && rb;
            c = db || rb;
            wx = 1;
         end
         7: ;
         8: v = dv;
         9: v = mv;
         default: wrest = 0;
      endcase
      if (op == 2 || op == 3 || op == 6) z = f[2] && zero;
      x = c;
      model = {wx, wrest, wrest, wrest, wrest,
               wx ? x : f[4], wrest ? n : f[3], wrest ? z : f[2],
               wrest ? v : f[1], wrest ? c : f[0]};
   endfunction

   function automatic string class_tag(input int op);
      case (op)
         0, 2:    class_tag = "R3";
         1, 3:    class_tag = "R4";
         4:       class_tag = "R9";
         5, 6:    class_tag = "R5";
         7:       class_tag = "R7";
         8, 9:    class_tag = "R8";
         default: class_tag = "R11";
      endcase
   endfunction

   task automatic apply(input logic [3:0] op, input logic [1:0] size,
                        input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
                        input logic [4:0] f, input bit dv, input bit mv);
      logic [9:0] exp;
      string      tag;
      @(posedge clk);
      opc = op; sz = size; src = s; dst = d; res = r; fin = f; dovf = dv; movf = mv;
      @(negedge clk);
      exp = model(s, d, r, f, int'(op), int'(size), dv, mv);
      n_vec++;
      if ({fwe, fout} !== exp) begin
         n_bad++;
         tag = class_tag(int'(op));
         if (fout[3] !== exp[3]) tag = {tag, " R1"};
         if (fout[2] !== exp[2]) tag = {tag, (op == 2 || op == 3 || op == 6) ? " R6" : " R2"};
         if (fwe[4] !== exp[9] || fout[4] !== exp[4]) tag = {tag, " R10"};
         $display("FAIL %s op=%0d size=%0d: we/flags actual=%b/%b expected=%b/%b",
                  tag, op, size, fwe, fout, exp[9:5], exp[4:0]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      src = '0; dst = '0; res = '0; fin = '0; opc = '0; sz = '0; dovf = 0; movf = 0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // reset state: all-zero inputs, add class (R2 zero result sets Z)
      apply(4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 5'h00, 0, 0);
      // R3/R1: byte 0x7F+0x01 = 0x80, upper garbage ignored
      apply(4'd0, 2'd0, 32'hFFFF_FF01, 32'h1234_567F, 32'hABCD_EF80, 5'h00, 0, 0);
      // R3/R2: byte 0xFF+0x01 = 0x00 with nonzero upper bits -> Z=1, C=X=1
      apply(4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 32'hFFFF_FF00, 5'h00, 0, 0);
      // R4: word 0x0000 - 0x0001 borrows
      apply(4'd1, 2'd1, 32'h0000_0001, 32'h0000_0000, 32'h0000_FFFF, 5'h00, 0, 0);
      // R4: long 0x80000000 - 1 overflows
      apply(4'd1, 2'd2, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 5'h00, 0, 0);
      // R5: negate long 0x80000000
      apply(4'd5, 2'd2, 32'h0, 32'h8000_0000, 32'h8000_0000, 5'h00, 0, 0);
      // R5: negate of zero
      apply(4'd5, 2'd1, 32'h0, 32'h0, 32'h0, 5'h1F, 0, 0);
      // R6: sticky Z with zero low word, incoming Z 1 then 0
      apply(4'd2, 2'd1, 32'h0, 32'h0, 32'hABCD_0000, 5'h04, 0, 0);
      apply(4'd2, 2'd1, 32'h0, 32'h0, 32'hABCD_0000, 5'h00, 0, 0);
      apply(4'd3, 2'd0, 32'h1, 32'h1, 32'h0000_0100, 5'h04, 0, 0);
      apply(4'd6, 2'd2, 32'h0, 32'h1, 32'hFFFF_FFFF, 5'h04, 0, 0);
      // R9: compare keeps X=1
      apply(4'd4, 2'd0, 32'h0000_0005, 32'h0000_0003, 32'h0000_00FE, 5'h10, 0, 0);
      // R7: logic with all flags set keeps X
      apply(4'd7, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 5'h1F, 0, 0);
      // R8: divide and multiply overflow inputs
      apply(4'd8, 2'd1, 32'h0, 32'h0, 32'h0000_1234, 5'h13, 1, 0);
      apply(4'd9, 2'd1, 32'h0, 32'h0, 32'h0000_0000, 5'h11, 1, 1);
      apply(4'd9, 2'd2, 32'h0, 32'h0, 32'h0000_0000, 5'h11, 0, 0);
      // R11: reserved codes 10..15 write nothing
      for (int k = 10; k < 16; k++) begin
         apply(4'(k), 2'd2, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'h15, 1, 1);
         apply(4'(k), 2'd0, 32'h0, 32'hFFFF_FFFF, 32'h8000_0080, 5'h0A, 0, 1);
      end
      // R1: size 3 behaves as long
      apply(4'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 5'h00, 0, 0);
      // random coverage of all classes and sizes (R1..R11), consistent and arbitrary results
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [31:0] rs, rd, rr;
         int          rop;
         rs  = $urandom;
         rd  = $urandom;
         rop = $urandom_range(0, 15);
         case (i % 4)
            0: rr = rs + rd;
            1: rr = rd - rs;
            2: rr = 32'h0 - rd;
            default: rr = $urandom;
         endcase
         if (i % 16 == 5) rr = rr & 32'hFFFF_0000;
         if (i % 16 == 9) rr = rr & 32'hFFFF_FF00;
         apply(4'(rop), 2'($urandom_range(0, 3)), rs, rd, rr, 5'($urandom),
               1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule